// File: doc/BRIEF.md
# Self-Starting Power-On Reset Generator

This block makes a reset for logic that has no reset pin and no usable global reset net. An 8-bit linear feedback shift register starts from whatever value its flops hold at power-up and advances once per clock. The reset output stays active for as long as the register's state differs from one terminal pattern, which is set by a parameter. When the register reaches that pattern, it stops advancing, and the reset falls and stays low.

The terminal pattern holds both zeros and ones. A register that powers up uniformly cleared or uniformly set therefore never releases reset on the first clock. The feedback is XNOR-based, and it has an explicit escape from the one state that XNOR feedback can lock in, so every start value reaches the terminal pattern. Both output polarities come straight from flops. They can drive asynchronous resets in the fabric or a global reset source without glitches.

Top module: `selfstart_reset`

## Requirements
- R1: Before the first clock edge, `rst_o` is 1 and `rst_no` is 0. The output flops power up in that state.
- R2: After each clock edge, `rst_o` is 1 exactly when the register value held before that edge differed from `TERMINAL`. This is a one-edge registered lag.
- R3: Once the register equals `TERMINAL`, it keeps that value on every later edge. After `rst_o` falls, it never rises again, so it falls exactly once.
- R4: Feedback is the XNOR of the register bits selected by `TAP_MASK` (default 0xB8, bits 7, 5, 4, 3), shifted into bit 0 as the other bits move up one place. A register that is all ones steps to all zeros.
- R5: `TERMINAL` must contain both 0 and 1 bits, and elaboration rejects any other value. Starting from all zeros or all ones, `rst_o` is still 1 after the first edge.
- R6: Starting from all zeros, `TERMINAL` lies at least `MIN_HOLD` (default 16) steps along the sequence, and elaboration rejects any closer value. `rst_o` therefore stays high for at least `MIN_HOLD` edges.
- R7: From any start value, `rst_o` falls within 2^WIDTH edges.
- R8: `rst_no` is the complement of `rst_o` at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_o | output | 1 | Active-high reset, registered |
| rst_no | output | 1 | Active-low copy of the reset, registered |

## Verification
The register advances on each clock edge. The reset flops sample the state held before that edge, so a change in `rst_o` appears one edge after the register value that caused it. The bench keeps a behavioural model of the sequence for several power-up values: all zeros, all ones, an arbitrary value, and the terminal pattern itself. It compares both outputs with the model at every falling clock edge, which lies half a period after each update. Release edge numbers are recorded from those samples and checked against the minimum hold time, the upper bound, and the one-step offset between the all-ones and all-zeros starts.

// File: rtl/selfstart_pkg.sv
package selfstart_pkg;

  localparam int MAXW = 32;

  function automatic logic [MAXW-1:0] width_mask(input int width);
    logic [MAXW-1:0] m;
    m = '0;
    for (int i = 0; i < MAXW; i++) begin
      if (i < width) m[i] = 1'b1;
    end
    return m;
  endfunction

  // One step of the XNOR sequence with lock-up escape.
  function automatic logic [MAXW-1:0] lfsr_step(input logic [MAXW-1:0] cur,
                                                input logic [MAXW-1:0] taps,
                                                input int width);
    logic [MAXW-1:0] full;
    logic            fb;
    full = width_mask(width);
    if ((cur & full) == full) return '0;
    fb = ~(^(cur & taps & full));
    return ((cur << 1) | {{(MAXW-1){1'b0}}, fb}) & full;
  endfunction

  // Number of steps from one value to another; -1 if never reached.
  function automatic int steps_between(input logic [MAXW-1:0] from_v,
                                       input logic [MAXW-1:0] to_v,
                                       input logic [MAXW-1:0] taps,
                                       input int width);
    logic [MAXW-1:0] cur;
    cur = from_v;
    for (int i = 0; i <= (1 << width); i++) begin
      if (cur == to_v) return i;
      cur = lfsr_step(cur, taps, width);
    end
    return -1;
  endfunction

  function automatic bit pattern_mixed(input logic [MAXW-1:0] pat, input int width);
    logic [MAXW-1:0] full;
    full = width_mask(width);
    return ((pat & full) != '0) && ((pat & full) != full);
  endfunction

endpackage

// File: rtl/selfstart_lfsr.sv
module selfstart_lfsr #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8,
  parameter logic [WIDTH-1:0] START    = '0
) (
  input  logic             clk,
  input  logic             hold,
  output logic [WIDTH-1:0] state,
  output logic             escape
);
  import selfstart_pkg::*;

  logic [WIDTH-1:0] state_q = START;
  logic [MAXW-1:0]  next_wide;
  logic [WIDTH-1:0] next_state;

  always_comb begin
    next_wide  = lfsr_step(MAXW'(state_q), MAXW'(TAP_MASK), WIDTH);
    next_state = next_wide[WIDTH-1:0];
  end

  assign escape = &state_q;

  always_ff @(posedge clk) begin
    if (!hold) state_q <= next_state;
  end

  assign state = state_q;
endmodule

// File: rtl/selfstart_match.sv
module selfstart_match #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] TERMINAL = 8'hE5
) (
  input  logic [WIDTH-1:0] state,
  output logic             at_terminal
);
  assign at_terminal = (state == TERMINAL);
endmodule

// File: rtl/selfstart_outreg.sv
module selfstart_outreg (
  input  logic clk,
  input  logic assert_req,
  output logic rst_o,
  output logic rst_no
);
  logic act_hi_q = 1'b1;
  logic act_lo_q = 1'b0;

  always_ff @(posedge clk) begin
    act_hi_q <= assert_req;
    act_lo_q <= ~assert_req;
  end

  assign rst_o  = act_hi_q;
  assign rst_no = act_lo_q;
endmodule

// File: rtl/selfstart_reset.sv
module selfstart_reset #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] TAP_MASK = 8'hB8,
  parameter logic [WIDTH-1:0] TERMINAL = 8'hE5,
  parameter logic [WIDTH-1:0] START    = '0,
  parameter int               MIN_HOLD = 16
) (
  input  logic clk,
  output logic rst_o,
  output logic rst_no
);
  import selfstart_pkg::*;

  localparam int TERM_DIST = steps_between('0, MAXW'(TERMINAL), MAXW'(TAP_MASK), WIDTH);

  if (!pattern_mixed(MAXW'(TERMINAL), WIDTH)) begin : g_bad_pattern
    $error("TERMINAL must mix 0 and 1 bits");
  end
  if (TERM_DIST < MIN_HOLD) begin : g_too_close
    $error("TERMINAL too close to the all-zero state");
  end

  logic [WIDTH-1:0] lfsr_state;
  logic             at_terminal;
  logic             lock_escape;

  selfstart_lfsr #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK), .START(START)) u_lfsr (
    .clk   (clk),
    .hold  (at_terminal),
    .state (lfsr_state),
    .escape(lock_escape)
  );

  selfstart_match #(.WIDTH(WIDTH), .TERMINAL(TERMINAL)) u_match (
    .state      (lfsr_state),
    .at_terminal(at_terminal)
  );

  selfstart_outreg u_out (
    .clk       (clk),
    .assert_req(~at_terminal),
    .rst_o     (rst_o),
    .rst_no    (rst_no)
  );
endmodule

// File: rtl/selfstart_reset_chk.sv
module selfstart_reset_chk #(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] TERMINAL = 8'hE5
) (
  input logic             clk,
  input logic             rst_o,
  input logic             rst_no,
  input logic [WIDTH-1:0] lfsr_state,
  input logic             at_terminal,
  input logic             lock_escape
);
  logic             started = 1'b0;
  logic [WIDTH+1:0] high_edges = '0;

  always_ff @(posedge clk) begin
    started <= 1'b1;
    if (rst_o) high_edges <= high_edges + 1'b1;
  end

  p_lag_r2: assert property (@(posedge clk) disable iff (!started)
    (lfsr_state != TERMINAL) |=> rst_o);

  p_hold_r3: assert property (@(posedge clk) disable iff (!started)
    at_terminal |=> ($stable(lfsr_state) && !rst_o));

  p_no_reassert_r3: assert property (@(posedge clk) disable iff (!started)
    !rst_o |=> !rst_o);

  p_escape_r4: assert property (@(posedge clk) disable iff (!started)
    lock_escape |=> (lfsr_state == '0));

  p_complement_r8: assert property (@(posedge clk) disable iff (!started)
    rst_no == !rst_o);

  p_bound_r7: assert property (@(posedge clk) disable iff (!started)
    high_edges <= (WIDTH+2)'(1 << WIDTH));
endmodule

bind selfstart_reset selfstart_reset_chk #(.WIDTH(WIDTH), .TERMINAL(TERMINAL)) u_chk (
  .clk        (clk),
  .rst_o      (rst_o),
  .rst_no     (rst_no),
  .lfsr_state (lfsr_state),
  .at_terminal(at_terminal),
  .lock_escape(lock_escape)
);

// File: tb/selfstart_reset_bench.sv
module selfstart_reset_bench;
  localparam int         N    = 4;
  localparam logic [7:0] TERM = 8'hE5;
  localparam logic [7:0] STARTS [N] = '{8'h00, 8'hFF, 8'h5A, 8'hE5};
  localparam int         CYCLES = 300;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [N-1:0] rst, rstn;

  for (genvar g = 0; g < N; g++) begin : g_inst
    selfstart_reset #(.TERMINAL(TERM), .START(STARTS[g])) u_selfstart_reset (
      .clk   (clk),
      .rst_o (rst[g]),
      .rst_no(rstn[g])
    );
  end

  int errors = 0;
  int checks = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural sequence step: XNOR of tap positions, all-ones goes to zero.
  function automatic int model_step(input int v);
    int taps [4] = '{7, 5, 4, 3};
    int ones = 0;
    if (v == 255) return 0;
    foreach (taps[k]) ones += (v >> taps[k]) & 1;
    return ((v << 1) & 255) | ((ones % 2 == 0) ? 1 : 0);
  endfunction

  int cur [N];
  int exp_rst [N];
  int rel_edge [N];
  int falls [N];
  int first_edge_rst [N];
  int prev [N];

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      cur[i] = int'(STARTS[i]); exp_rst[i] = 1; rel_edge[i] = -1;
      falls[i] = 0; prev[i] = 1; first_edge_rst[i] = -1;
    end
    #1;
    for (int i = 0; i < N; i++) begin
      check(rst[i] == 1'b1, "R1 rst_o at power-up", int'(rst[i]), 1);
      check(rstn[i] == 1'b0, "R1 rst_no at power-up", int'(rstn[i]), 0);
    end
    for (int e = 1; e <= CYCLES; e++) begin
      // advance model across edge e
      for (int i = 0; i < N; i++) begin
        exp_rst[i] = (cur[i] != int'(TERM)) ? 1 : 0;
        if (cur[i] != int'(TERM)) cur[i] = model_step(cur[i]);
      end
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        check(int'(rst[i]) == exp_rst[i], "R2 rst_o vs model", int'(rst[i]), exp_rst[i]);
        check(rstn[i] == ~rst[i], "R8 rst_no complement", int'(rstn[i]), int'(~rst[i]));
        if (e == 1) first_edge_rst[i] = int'(rst[i]);
        if (prev[i] == 1 && rst[i] == 1'b0) begin
          falls[i]++;
          if (rel_edge[i] < 0) rel_edge[i] = e;
        end
        if (prev[i] == 0 && rst[i] == 1'b1) falls[i] += 100;
        prev[i] = int'(rst[i]);
      end
    end
    for (int i = 0; i < N; i++) begin
      check(falls[i] == 1, "R3 single release, no reassert", falls[i], 1);
      check(rel_edge[i] > 0 && rel_edge[i] <= 256, "R7 release bound", rel_edge[i], 256);
    end
    check(first_edge_rst[0] == 1, "R5 zero start held after edge 1", first_edge_rst[0], 1);
    check(first_edge_rst[1] == 1, "R5 ones start held after edge 1", first_edge_rst[1], 1);
    check(rel_edge[0] >= 16, "R6 minimum hold from zero", rel_edge[0], 16);
    check(rel_edge[1] == rel_edge[0] + 1, "R4 all-ones escapes to zero", rel_edge[1], rel_edge[0] + 1);
    check(rel_edge[3] == 1, "R3 terminal start releases at edge 1", rel_edge[3], 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule